// File: doc/BRIEF.md
# Translation-Entry DMA Address Lookup

This block translates device-side DMA bus addresses into system addresses through a table of 64-bit translation entries held in on-chip flops. A request address is cut into a table index and a page offset by a run-time page shift. The indexed entry supplies the translated page base and two permission bits. The result returns one cycle later with a valid strobe. It carries the page-aligned request address, the translated page base, a mask that covers the in-page offset, and separate read and write grants.

A request whose index lands at or beyond the configured entry count does not fault. It returns a no-access result: no grants, a zero translated base and an all-ones offset mask. A separate single-port table access path lets a neighbouring block fill entries and read them back. A configuration write loads the page shift and the entry count together. A synchronous reset empties the table, so every page is no-access until software writes it.

Top module: `tce_xlate_unit`

## Requirements
- R1: Synchronous active-low reset zeroes every table entry, sets the page shift to 12 and the entry count to 0, and holds `rsp_valid` and `tbl_rvalid` low.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, so every lookup has one cycle of latency.
- R3: The table index is `req_addr >> shift`. The lookup hits when that index, compared at full width, is below the entry count.
- R4: On a hit, with page mask `pm = ~((1 << shift) - 1)`, `rsp_iova = req_addr & pm` and `rsp_xaddr = entry & pm`.
- R5: On a hit, `rsp_mask = ~pm`, which sets the low `shift` bits only.
- R6: Permission comes from entry bits [1:0]. Bit 0 grants read and bit 1 grants write: 00 gives no access, 01 read only, 10 write only, 11 read and write.
- R7: On a miss, `rsp_rd` and `rsp_wr` are 0, `rsp_xaddr` is 0, `rsp_mask` is all ones and `rsp_iova` equals `req_addr`.
- R8: `tbl_we` stores `tbl_wdata` at `tbl_idx` when `tbl_idx < DEPTH` and is ignored otherwise. `tbl_re` returns the entry at `tbl_idx` on `tbl_rdata`, with `tbl_rvalid` high, one cycle later.
- R9: `cfg_we` loads the page shift and the entry count. A count above `DEPTH` is clamped to `DEPTH`.
- R10: A lookup in the same cycle as a table write to its entry returns the entry's previous contents. The new contents are seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load page shift and entry count |
| cfg_shift | input | SHIFT_W (6) | New page shift |
| cfg_count | input | CNT_W (5) | New entry count |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_re | input | 1 | Table entry read strobe |
| tbl_idx | input | TIDX_W (5) | Table entry index for write or read |
| tbl_wdata | input | ADDR_W (64) | Entry value to write |
| tbl_rvalid | output | 1 | Read data valid |
| tbl_rdata | output | ADDR_W (64) | Entry value read back |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W (64) | Bus address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_iova | output | ADDR_W (64) | Page-aligned request address (request address on a miss) |
| rsp_xaddr | output | ADDR_W (64) | Translated page base |
| rsp_mask | output | ADDR_W (64) | In-page offset mask |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |

## Verification
A corrupted table entry shows only when that page is looked up or read back. The next response then carries a wrong base or wrong grants, one cycle after the request. A wrong shift or count register changes every later response at once, through misaligned bases, wrong mask widths, or hits and misses on the wrong side of the window edge. The bench therefore probes each side of that edge, and the table port shows directly whether a write stayed within range.

// File: rtl/tce_pkg.sv
// Shared types for the translation-entry lookup unit.
// Assumes: entries hold the permission code in bits [1:0].
package tce_pkg;

    // Permission code carried in the low two bits of every entry.
    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RD   = 2'b01,
        PERM_WR   = 2'b10,
        PERM_RW   = 2'b11
    } perm_e;

    // Reset value of the page shift register (4 KiB pages).
    localparam int RESET_SHIFT = 12;

    function automatic logic perm_reads(perm_e p);
        return (p == PERM_RD) || (p == PERM_RW);
    endfunction

    function automatic logic perm_writes(perm_e p);
        return (p == PERM_WR) || (p == PERM_RW);
    endfunction

endpackage

// File: rtl/tce_cfg_regs.sv
// Configuration registers: page shift and number of valid entries.
// Assumes: the writer may present any count; values above DEPTH are clamped.
module tce_cfg_regs #(
    parameter int ADDR_W  = 64,
    parameter int DEPTH   = 16,
    parameter int SHIFT_W = $clog2(ADDR_W),
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [CNT_W-1:0]   cfg_count,
    output logic [SHIFT_W-1:0] shift_q,
    output logic [CNT_W-1:0]   count_q
);
    import tce_pkg::*;

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count_clamped;

    // Clamp the requested entry count to the physical table depth.
    always_comb begin
        count_clamped = (cfg_count > MAX_CNT) ? MAX_CNT : cfg_count;
    end

    // Hold shift and count; reset to 4 KiB pages and an empty window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= SHIFT_W'(RESET_SHIFT);
            count_q <= '0;
        end else if (cfg_we) begin
            shift_q <= cfg_shift;
            count_q <= count_clamped;
        end
    end

    // R9: the stored count never exceeds the table depth.
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= MAX_CNT);

    // R9: a configuration write lands in the registers one cycle later.
    a_r9_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (shift_q == $past(cfg_shift)));

endmodule

// File: rtl/tce_table.sv
// Entry storage: DEPTH flop entries, one write/read port for the filler
// and one combinational lookup port. Synchronous reset clears all entries.
// Assumes: lookup index is masked to a legal slot by the caller or here.
module tce_table #(
    parameter int ADDR_W = 64,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int TIDX_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic              tbl_re,
    input  logic [TIDX_W-1:0] tbl_idx,
    input  logic [ADDR_W-1:0] tbl_wdata,
    output logic              tbl_rvalid,
    output logic [ADDR_W-1:0] tbl_rdata,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [ADDR_W-1:0] lk_entry
);
    logic [ADDR_W-1:0] mem [DEPTH];
    logic              in_range;
    logic              any_set;

    // Write and read requests only address a slot below DEPTH.
    always_comb begin
        in_range = (tbl_idx < TIDX_W'(DEPTH));
    end

    // One register per slot, each with its own decoded write enable.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_w;
        always_comb begin
            hit_w = tbl_we && in_range && (tbl_idx == TIDX_W'(g));
        end

        // Store the slot value; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (hit_w) begin
                mem[g] <= tbl_wdata;
            end
        end

        // R8: a slot changes only when written at its own index.
        a_r8_slot_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !(tbl_we && tbl_idx == TIDX_W'(g)) |=> $stable(mem[g]));
    end

    // Registered read-back for the filler port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_rvalid <= 1'b0;
            tbl_rdata  <= '0;
        end else begin
            tbl_rvalid <= tbl_re;
            if (tbl_re) begin
                tbl_rdata <= in_range ? mem[tbl_idx[IDX_W-1:0]] : '0;
            end
        end
    end

    // Combinational lookup read (old contents during a same-cycle write).
    always_comb begin
        lk_entry = (32'(lk_idx) < DEPTH) ? mem[lk_idx] : '0;
    end

    // OR of all entries, used to check the reset clear.
    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            any_set = any_set | (|mem[i]);
        end
    end

    // R1: the first cycle out of reset sees an empty table.
    a_r1_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !any_set);

    // R8: read data follows a read strobe by one cycle.
    a_r8_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_re |=> tbl_rvalid);

endmodule

// File: rtl/tce_lookup.sv
// Lookup stage: splits the request address by the page shift, bounds-checks
// the index, decodes permissions and registers the result (1-cycle latency).
// Assumes: shift < ADDR_W, count <= DEPTH (guaranteed by tce_cfg_regs).
module tce_lookup #(
    parameter int ADDR_W  = 64,
    parameter int DEPTH   = 16,
    parameter int SHIFT_W = $clog2(ADDR_W),
    parameter int CNT_W   = $clog2(DEPTH + 1),
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CNT_W-1:0]   count,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic [IDX_W-1:0]   lk_idx,
    input  logic [ADDR_W-1:0]  lk_entry,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_iova,
    output logic [ADDR_W-1:0]  rsp_xaddr,
    output logic [ADDR_W-1:0]  rsp_mask,
    output logic               rsp_rd,
    output logic               rsp_wr
);
    import tce_pkg::*;

    logic [ADDR_W-1:0] page_mask;
    logic [ADDR_W-1:0] full_idx;
    logic              hit;
    perm_e             perm;
    logic [ADDR_W-1:0] n_iova, n_xaddr, n_mask;
    logic              n_rd, n_wr;

    // Page mask and full-width index from the current shift.
    always_comb begin
        page_mask = ~((ADDR_W'(1) << shift) - ADDR_W'(1));
        full_idx  = req_addr >> shift;
        hit       = full_idx < ADDR_W'(count);
        lk_idx    = full_idx[IDX_W-1:0];
    end

    // Form the next response for a hit or a no-access miss.
    always_comb begin
        perm = perm_e'(lk_entry[1:0]);
        if (hit) begin
            n_iova  = req_addr & page_mask;
            n_xaddr = lk_entry & page_mask;
            n_mask  = ~page_mask;
            n_rd    = perm_reads(perm);
            n_wr    = perm_writes(perm);
        end else begin
            n_iova  = req_addr;
            n_xaddr = '0;
            n_mask  = '1;
            n_rd    = 1'b0;
            n_wr    = 1'b0;
        end
    end

    // Result register: loads on a request, valid strobe follows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_iova  <= '0;
            rsp_xaddr <= '0;
            rsp_mask  <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_iova  <= n_iova;
                rsp_xaddr <= n_xaddr;
                rsp_mask  <= n_mask;
                rsp_rd    <= n_rd;
                rsp_wr    <= n_wr;
            end
        end
    end

    // R2: each request yields a response in the next cycle.
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: no response without a request.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R5: the offset mask is always a run of low ones.
    a_r5_mask_form: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (((rsp_mask + ADDR_W'(1)) & rsp_mask) == '0));

    // R4: hit addresses carry no offset bits.
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !(&rsp_mask)) |->
            (((rsp_iova & rsp_mask) == '0) && ((rsp_xaddr & rsp_mask) == '0)));

    // R7: an all-ones mask comes with no access and a zero base.
    a_r7_miss_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (&rsp_mask)) |-> (!rsp_rd && !rsp_wr && rsp_xaddr == '0));

endmodule

// File: rtl/tce_xlate_unit.sv
// Top: translation-entry DMA address lookup. Wires the configuration
// registers, the entry table and the lookup stage together.
// Assumes: filler writes and lookups may overlap; lookups see old data.
module tce_xlate_unit #(
    parameter int ADDR_W  = 64,
    parameter int DEPTH   = 16,
    parameter int SHIFT_W = $clog2(ADDR_W),
    parameter int CNT_W   = $clog2(DEPTH + 1),
    parameter int IDX_W   = $clog2(DEPTH),
    parameter int TIDX_W  = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               tbl_we,
    input  logic               tbl_re,
    input  logic [TIDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0]  tbl_wdata,
    output logic               tbl_rvalid,
    output logic [ADDR_W-1:0]  tbl_rdata,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_iova,
    output logic [ADDR_W-1:0]  rsp_xaddr,
    output logic [ADDR_W-1:0]  rsp_mask,
    output logic               rsp_rd,
    output logic               rsp_wr
);
    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   count_q;
    logic [IDX_W-1:0]   lk_idx;
    logic [ADDR_W-1:0]  lk_entry;

    tce_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .SHIFT_W(SHIFT_W),
        .CNT_W  (CNT_W)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_shift(cfg_shift),
        .cfg_count(cfg_count),
        .shift_q  (shift_q),
        .count_q  (count_q)
    );

    tce_table #(
        .ADDR_W(ADDR_W),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .TIDX_W(TIDX_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_we    (tbl_we),
        .tbl_re    (tbl_re),
        .tbl_idx   (tbl_idx),
        .tbl_wdata (tbl_wdata),
        .tbl_rvalid(tbl_rvalid),
        .tbl_rdata (tbl_rdata),
        .lk_idx    (lk_idx),
        .lk_entry  (lk_entry)
    );

    tce_lookup #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .SHIFT_W(SHIFT_W),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) lookup_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (shift_q),
        .count    (count_q),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .lk_idx   (lk_idx),
        .lk_entry (lk_entry),
        .rsp_valid(rsp_valid),
        .rsp_iova (rsp_iova),
        .rsp_xaddr(rsp_xaddr),
        .rsp_mask (rsp_mask),
        .rsp_rd   (rsp_rd),
        .rsp_wr   (rsp_wr)
    );

endmodule

// File: tb/tce_xlate_unit_tb.sv
// Bench for tce_xlate_unit: vector table walk, then directed corner tests.
module tce_xlate_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 64;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] iova;
        logic [AW-1:0] xaddr;
        logic [AW-1:0] mask;
        logic          rd;
        logic          wr;
    } vec_t;

    localparam logic [AW-1:0] ONES = '1;
    localparam logic [AW-1:0] M12  = 64'h0000_0000_0000_0FFF;

    // Shift 12, count 8, entries 0,1,2,3,7 loaded as below.
    localparam vec_t VECS [8] = '{
        '{64'h0000_0000_0000_0ABC, 64'h0, 64'h0000_0000_1234_5000, M12, 1'b1, 1'b1},
        '{64'h0000_0000_0000_1FFF, 64'h1000, 64'h0000_00AB_CDEF_1000, M12, 1'b1, 1'b0},
        '{64'h0000_0000_0000_2000, 64'h2000, 64'hFFFF_0000_0000_0000, M12, 1'b0, 1'b1},
        '{64'h0000_0000_0000_3456, 64'h3000, 64'h0000_0000_0000_7000, M12, 1'b0, 1'b0},
        '{64'h0000_0000_0000_7FFF, 64'h7000, 64'h8000_0000_0000_0000, M12, 1'b1, 1'b1},
        '{64'h0000_0000_0000_8000, 64'h8000, 64'h0, ONES, 1'b0, 1'b0},
        '{64'h0000_0000_0000_4000, 64'h4000, 64'h0, M12, 1'b0, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, ONES, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_shift = '0;
    logic [4:0]    cfg_count = '0;
    logic          tbl_we = 1'b0;
    logic          tbl_re = 1'b0;
    logic [4:0]    tbl_idx = '0;
    logic [AW-1:0] tbl_wdata = '0;
    logic          tbl_rvalid;
    logic [AW-1:0] tbl_rdata;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_iova, rsp_xaddr, rsp_mask;
    logic          rsp_rd, rsp_wr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    tce_xlate_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_shift(cfg_shift), .cfg_count(cfg_count),
        .tbl_we(tbl_we), .tbl_re(tbl_re), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_xaddr(rsp_xaddr),
        .rsp_mask(rsp_mask), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: ran %0d cycles, expected under 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_cfg(input logic [5:0] s, input logic [4:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_shift = s; cfg_count = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_wr(input logic [4:0] idx, input logic [AW-1:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic do_rd(input string tag, input logic [4:0] idx, input logic [AW-1:0] exp);
        @(negedge clk);
        tbl_re = 1'b1; tbl_idx = idx;
        @(negedge clk);
        tbl_re = 1'b0;
        checks++;
        if (tbl_rvalid !== 1'b1 || tbl_rdata !== exp) begin
            fails++;
            $display("FAIL %s: rvalid=%b data=%h expected rvalid=1 data=%h",
                     tag, tbl_rvalid, tbl_rdata, exp);
        end
    endtask

    task automatic check_rsp(input string tag, input vec_t e);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_iova !== e.iova || rsp_xaddr !== e.xaddr ||
            rsp_mask !== e.mask || rsp_rd !== e.rd || rsp_wr !== e.wr) begin
            fails++;
            $display("FAIL %s: v=%b iova=%h xa=%h mask=%h rd=%b wr=%b expected v=1 iova=%h xa=%h mask=%h rd=%b wr=%b",
                     tag, rsp_valid, rsp_iova, rsp_xaddr, rsp_mask, rsp_rd, rsp_wr,
                     e.iova, e.xaddr, e.mask, e.rd, e.wr);
        end
    endtask

    task automatic lookup(input string tag, input vec_t e);
        @(negedge clk);
        req_valid = 1'b1; req_addr = e.addr;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, e);
    endtask

    task automatic mk_check(input string tag, input logic [AW-1:0] a, input logic [AW-1:0] iv,
                            input logic [AW-1:0] xa, input logic [AW-1:0] m,
                            input logic r, input logic w);
        vec_t e;
        e = '{a, iv, xa, m, r, w};
        lookup(tag, e);
    endtask

    initial begin
        do_reset();
        // R1: reset state at the ports
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || tbl_rvalid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: rsp_valid=%b tbl_rvalid=%b expected 0 0",
                     rsp_valid, tbl_rvalid);
        end
        // R1/R7: count is 0 after reset, so any address misses
        mk_check("R1 empty window after reset", 64'h0, 64'h0, 64'h0, ONES, 1'b0, 1'b0);
        // R2: no request, no response
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2 idle cycle: rsp_valid=%b expected 0", rsp_valid);
        end

        // Fill the table and configure shift 12, count 8
        do_cfg(6'd12, 5'd8);
        do_wr(5'd0, 64'h0000_0000_1234_5003);
        do_wr(5'd1, 64'h0000_00AB_CDEF_1001);
        do_wr(5'd2, 64'hFFFF_0000_0000_0FF2);
        do_wr(5'd3, 64'h0000_0000_0000_7000);
        do_wr(5'd7, 64'h8000_0000_0000_0003);

        // R3 R4 R5 R6 R7: table walk
        for (int i = 0; i < 8; i++) begin
            lookup($sformatf("R3/R4/R5/R6/R7 vector %0d", i), VECS[i]);
        end

        // R2: back-to-back requests each get a response
        @(negedge clk);
        req_valid = 1'b1; req_addr = VECS[0].addr;
        @(negedge clk);
        req_addr = VECS[1].addr;
        check_rsp("R2 back-to-back first", VECS[0]);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R2 back-to-back second", VECS[1]);

        // R8: readback and ignored out-of-range write (index 17 aliases slot 1)
        do_rd("R8 readback slot 0", 5'd0, 64'h0000_0000_1234_5003);
        do_wr(5'd17, 64'hDEAD_BEEF_DEAD_BEEF);
        do_rd("R8 out-of-range write ignored", 5'd1, 64'h0000_00AB_CDEF_1001);

        // R3 R4 R5: shift 16 changes index split and mask
        do_cfg(6'd16, 5'd8);
        mk_check("R3/R4 shift 16 hit", 64'h0000_0000_0001_2345, 64'h0001_0000,
                 64'h0000_00AB_CDEF_0000, 64'hFFFF, 1'b1, 1'b0);
        mk_check("R3 last in-window page", 64'h0000_0000_0007_FFFF, 64'h0007_0000,
                 64'h8000_0000_0000_0000, 64'hFFFF, 1'b1, 1'b1);
        mk_check("R3 first out-of-window page", 64'h0000_0000_0008_0000,
                 64'h0008_0000, 64'h0, ONES, 1'b0, 1'b0);

        // R9: count above DEPTH is clamped to 16
        do_cfg(6'd12, 5'd31);
        mk_check("R9 clamp slot 15 hits", 64'hF123, 64'hF000, 64'h0, M12, 1'b0, 1'b0);
        mk_check("R9 clamp index 16 misses", 64'h1_0000, 64'h1_0000, 64'h0, ONES, 1'b0, 1'b0);

        // R10: lookup in same cycle as write sees old entry
        do_cfg(6'd12, 5'd8);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 5'd5; tbl_wdata = 64'h0000_0000_0000_9003;
        req_valid = 1'b1; req_addr = 64'h5010;
        @(negedge clk);
        tbl_we = 1'b0; req_valid = 1'b0;
        check_rsp("R10 same-cycle write shows old entry",
                  '{64'h5010, 64'h5000, 64'h0, M12, 1'b0, 1'b0});
        mk_check("R10 next lookup shows new entry", 64'h5010, 64'h5000,
                 64'h9000, M12, 1'b1, 1'b1);

        // R1: reset again empties the table and the window
        do_reset();
        do_rd("R1 slot 0 cleared", 5'd0, 64'h0);
        mk_check("R1 count cleared by reset", 64'h0ABC, 64'h0ABC, 64'h0, ONES, 1'b0, 1'b0);
        do_cfg(6'd12, 5'd8);
        mk_check("R1 entry 0 no-access after reset", 64'h0ABC, 64'h0, 64'h0, M12, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule